// File: doc/BRIEF.md
# Interrupt Pin Level Router

This block takes eight active-high external interrupt inputs and steers each one onto a level of a fifteen-level processor interrupt space. Each pin owns a 4-bit routing code. Pins 0 to 3 keep their codes in one 16-bit select register and pins 4 to 7 keep theirs in a second one. A per-level mask can be changed without a read-modify-write. One write address sets mask bits and another clears them.

Pin inputs pass through a two-flop synchroniser before they are used. A request is level-sensitive. It exists for as long as the synchronised pin is high, the pin's code names a valid level, and that level is unmasked. Pins that share a level are ORed together. The block presents the resulting pending vector and the number of the highest pending level. A small register bus writes the select registers and the mask and reads them back.

Top module: `irq_pin_router`

## Requirements
- R1: After reset, both select registers read 0x0000, the mask reads 0xFFFF (every level masked), the pending vector is 0 and the level output is 0.
- R2: Bus address 0 holds the select register for pins 0–3 and address 1 holds the one for pins 4–7. The code of pin n sits at bits [4*(n mod 4)+3 : 4*(n mod 4)] of its register. A write replaces the whole register, and a read returns the last value written.
- R3: A pin whose code is 0 raises no request, and neither does a pin whose code is 15. Pending bits 0 and 15 are never set.
- R4: Writing to address 2 sets every mask bit that has a one in the written word and leaves the other mask bits unchanged. Reading address 2 or address 3 returns the mask, where bit k masks level k.
- R5: Writing to address 3 clears every mask bit that has a one in the written word and leaves the other mask bits unchanged.
- R6: Pending bit L is set exactly when some synchronised pin is high, carries code L with L in 1..14, and level L is unmasked. The bit drops when the pin drops.
- R7: When several pins carry the same code, that level stays pending while any one of them is high.
- R8: A pin change first shows on the pending vector after the second rising clock edge that samples it.
- R9: The level output is the highest-numbered pending level, or 0 when nothing is pending.
- R10: A masked level never shows as pending, whatever its pins do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pins | input | 8 | External interrupt inputs, active high, asynchronous |
| bus_addr | input | 2 | Register address: 0 low select, 1 high select, 2 mask set, 3 mask clear |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| irq_pending | output | 16 | Unmasked pending vector, bit k for level k |
| irq_level | output | 4 | Highest pending level, 0 if none |

## Verification
The bench uses the default parameters: eight pins, 4-bit codes, 16-bit registers and a two-stage synchroniser. With these values every code from 0 to 15 can be written and reached, including the two unrouted codes. Pins can share a level, and a shared level can also be masked. A behavioural model of the registers and of the two-stage pin delay is compared against the read data, the pending vector and the level output on every clock. This comparison runs through directed phases and then through a long stretch of random pin, routing and mask traffic.

// File: rtl/irq_pin_router.sv
module irq_pin_router #(
  parameter int LEVEL_W     = 4,
  parameter int REG_W       = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             irq_pins,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic [REG_W-1:0]       bus_wdata,
  output logic [REG_W-1:0]       bus_rdata,
  output logic [(1<<LEVEL_W)-1:0] irq_pending,
  output logic [LEVEL_W-1:0]     irq_level
);
  localparam int PINS_PER_REG = REG_W / LEVEL_W;
  localparam int NUM_PINS     = 2 * PINS_PER_REG;
  localparam int NUM_LEVELS   = 1 << LEVEL_W;
  localparam int TOP_LEVEL    = NUM_LEVELS - 1;
  localparam logic [ADDR_W-1:0] A_SEL_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEL_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MSET   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MCLR   = ADDR_W'(3);

  logic [NUM_PINS-1:0]   sync_q [SYNC_STAGES];
  logic [REG_W-1:0]      sel_q  [2];
  logic [NUM_LEVELS-1:0] mask_q;
  logic [LEVEL_W-1:0]    pin_lvl [NUM_PINS];
  logic [NUM_LEVELS-1:0] raw_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= irq_pins[NUM_PINS-1:0];
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q[0] <= '0;
      sel_q[1] <= '0;
      mask_q   <= '1;
    end else if (bus_wr) begin
      case (bus_addr)
        A_SEL_LO: sel_q[0] <= bus_wdata;
        A_SEL_HI: sel_q[1] <= bus_wdata;
        A_MSET:   mask_q   <= mask_q | bus_wdata[NUM_LEVELS-1:0];
        default:  mask_q   <= mask_q & ~bus_wdata[NUM_LEVELS-1:0];
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_lvl[p] = sel_q[p / PINS_PER_REG][(p % PINS_PER_REG)*LEVEL_W +: LEVEL_W];
  end

  always_comb begin
    raw_req = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (sync_q[SYNC_STAGES-1][p] && pin_lvl[p] != '0 && pin_lvl[p] != LEVEL_W'(TOP_LEVEL))
        raw_req[pin_lvl[p]] = 1'b1;
  end

  assign irq_pending = raw_req & ~mask_q;

  always_comb begin
    irq_level = '0;
    for (int l = 1; l < NUM_LEVELS; l++)
      if (irq_pending[l]) irq_level = LEVEL_W'(l);
  end

  always_comb begin
    case (bus_addr)
      A_SEL_LO: bus_rdata = sel_q[0];
      A_SEL_HI: bus_rdata = sel_q[1];
      default:  bus_rdata = REG_W'(mask_q);
    endcase
  end

  AST_SEL_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_SEL_LO) |=> $stable(sel_q[0])); // R2
  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pending[0] && !irq_pending[TOP_LEVEL]); // R3
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MSET) |=>
      ((mask_q & $past(bus_wdata[NUM_LEVELS-1:0])) == $past(bus_wdata[NUM_LEVELS-1:0]))); // R4
  AST_MASK_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MSET) |=>
      ((mask_q & ~$past(bus_wdata[NUM_LEVELS-1:0])) == ($past(mask_q) & ~$past(bus_wdata[NUM_LEVELS-1:0])))); // R4
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MCLR) |=>
      ((mask_q & $past(bus_wdata[NUM_LEVELS-1:0])) == '0)); // R5
  AST_LEVEL_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> irq_pending[irq_level]); // R9
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending & mask_q) == '0); // R10
endmodule

// File: tb/irq_pin_router_bench.sv
module irq_pin_router_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pins = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] irq_pending;
  logic [3:0]  irq_level;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [15:0] m_sel_lo, m_sel_hi, m_mask;
  logic [7:0]  m_s1, m_s2;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pin_router u_irq_pin_router (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pending(irq_pending), .irq_level(irq_level));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel_lo = 16'h0; m_sel_hi = 16'h0; m_mask = 16'hFFFF;
      m_s1 = '0; m_s2 = '0;
    end else begin
      if (bus_wr) begin
        if (bus_addr == 2'd0) m_sel_lo = bus_wdata;
        else if (bus_addr == 2'd1) m_sel_hi = bus_wdata;
        else if (bus_addr == 2'd2) m_mask = m_mask | bus_wdata;
        else m_mask = m_mask & ~bus_wdata;
      end
      m_s2 = m_s1;
      m_s1 = irq_pins;
    end
  end

  function automatic logic [15:0] ref_pending();
    logic [15:0] v = '0;
    for (int p = 0; p < 8; p++) begin
      int code = (p < 4) ? ((m_sel_lo >> (4*p)) & 15) : ((m_sel_hi >> (4*(p-4))) & 15);
      if (m_s2[p] && code >= 1 && code <= 14 && !m_mask[code]) v[code] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [3:0] ref_level(input logic [15:0] pend);
    int best = 0;
    for (int l = 0; l < 16; l++) if (pend[l]) best = l;
    return 4'(best);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [15:0] rd, pend;
    case (bus_addr)
      2'd0: rd = m_sel_lo;
      2'd1: rd = m_sel_hi;
      default: rd = m_mask;
    endcase
    pend = ref_pending();
    check(bus_addr < 2 ? "R2 readback" : (bus_addr == 2 ? "R4 mask read" : "R5 mask read"), bus_rdata, rd);
    check("R6 pending", irq_pending, pend);
    check("R9 level", {12'h0, irq_level}, {12'h0, ref_level(pend)});
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    bus_addr = a;
    #1;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    rd(0); check("R1 sel lo", bus_rdata, 16'h0000);
    rd(1); check("R1 sel hi", bus_rdata, 16'h0000);
    rd(2); check("R1 mask", bus_rdata, 16'hFFFF);
    check("R1 pending", irq_pending, 16'h0);
    check("R1 level", {12'h0, irq_level}, 16'h0);

    // pin0 code 0, pin1 1, pin2 2, pin3 3; pin4 15, pin5 5, pin6 5, pin7 14
    wr(0, 16'h3210);
    wr(1, 16'hE55F);
    rd(0); check("R2 lo field layout", bus_rdata, 16'h3210);
    rd(1); check("R2 hi field layout", bus_rdata, 16'hE55F);
    wr(3, 16'hFFFF);
    rd(3); check("R5 clear all", bus_rdata, 16'h0000);

    irq_pins = 8'h11;  // pin0 (code 0) and pin4 (code 15)
    step(); step(); step();
    check("R3 unrouted codes", irq_pending, 16'h0000);

    irq_pins = 8'h04;  // pin2 -> level 2
    step();
    check("R8 one edge", irq_pending, 16'h0000);
    step();
    check("R8 two edges", irq_pending, 16'h0004);
    check("R9 single", {12'h0, irq_level}, 16'h0002);

    irq_pins = 8'h64;  // pins 5,6 share level 5
    step(); step();
    check("R9 highest", {12'h0, irq_level}, 16'h0005);
    irq_pins = 8'h44;
    step(); step();
    check("R7 shared level held", irq_pending, 16'h0024);

    wr(2, 16'h0020);
    rd(2); check("R4 set one bit", bus_rdata, 16'h0020);
    check("R10 masked level", irq_pending, 16'h0004);
    irq_pins = 8'hFF;
    step(); step();
    check("R10 masked all pins", irq_pending, 16'h400E);
    check("R9 level 14", {12'h0, irq_level}, 16'h000E);
    wr(3, 16'h0020);
    rd(3); check("R5 clear one bit", bus_rdata, 16'h0000);
    check("R6 unmasked", irq_pending, 16'h402E);
    irq_pins = 8'h00;
    step(); step();
    check("R6 drop", irq_pending, 16'h0000);
    check("R9 none", {12'h0, irq_level}, 16'h0000);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 9);
      irq_pins = 8'($urandom);
      bus_addr = 2'($urandom);
      bus_wr = (r < 3);
      bus_wdata = 16'($urandom);
      step();
    end
    bus_wr = 1'b0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule